// File: doc/BRIEF.md
# Dual-Bank Flash Read Address Mapper

This block sits between a CPU read port and two flash bank arrays of equal size. For each CPU read it works out which bank or banks to read and at which in-bank word. It then returns the data, or it flags the read as unmapped. The bank arrays are outside the block. Each bank offers a 64-bit read port with a one-cycle registered latency and a busy flag, which is high while that bank is programming.

The block has two organisations. In split organisation each read returns one 64-bit word from one bank. Bank 2 always starts at the middle of the maximum address space, so devices smaller than the maximum have a hole between the two banks. In paired organisation each read returns a 128-bit line. The low half comes from bank 1 and the high half comes from the same word of bank 2, so the space has no hole. An exchange control makes the lower region fetch from bank 2 and the upper region fetch from bank 1. A read to one bank is served while the other bank programs.

The organisation, the exchange bit and the device size come from option bits that are already loaded. The block latches them only when it accepts a request.

Top module: `dbf_addr_map`

## Requirements
- R1: In split organisation (cfg_single=0, cfg_swap=0), with AW = SPACE_LOG2-3, rd_addr bit AW-1 selects the region: 0 selects bank 1 and 1 selects bank 2. Bits AW-2:0 give the bank word. rd_data[63:0] carries that word and rd_data[127:64] is zero. rd_ready rises 3 cycles after the clock edge that accepts the request.
- R2: In paired organisation (cfg_single=1), rd_addr bits AW-1:1 give a line index L. rd_data[63:0] is bank 1 word L and rd_data[127:64] is bank 2 word L. Both bank enables pulse together.
- R3: cfg_size sets the bank depth D in words: code 0 gives 2^(AW-1), code 1 gives half of that, code 2 gives a quarter, and code 3 gives 0. A split word index of D or more in either region is unmapped, which leaves a hole between the banks. A paired line index of D or more is unmapped.
- R4: An unmapped read returns rd_err=1, rd_ready=1 and rd_data all ones one cycle after acceptance. No bank enable is raised.
- R5: cfg_swap=1 in split organisation makes region 0 read bank 2 and region 1 read bank 1. In paired organisation cfg_swap has no effect.
- R6: A split read to one bank completes with R1 latency while the other bank's busy flag is high.
- R7: A read whose target bank is busy raises no bank enable and no rd_ready until that busy flag clears. rd_ready then follows 3 cycles after the busy flag is seen low. In paired organisation, busy on either bank stalls the read.
- R8: cfg_single, cfg_swap, cfg_size and rd_addr are latched only when a request is accepted in the idle state. Changes to them, and new requests, while a read is outstanding do not affect that read.
- R9: While reset is held, and in the first cycle after it is released, rd_ready, rd_err, b1_en and b2_en are low and rd_data is zero. The latched organisation resets to split.
- R10: In paired organisation, rd_addr bit 0 is ignored: two neighbouring word addresses return the same line.
- R11: rd_ready and rd_err are high for exactly one cycle per completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, accepted when the block is idle |
| rd_addr | input | SPACE_LOG2-3 | Read address in 64-bit word units |
| cfg_single | input | 1 | 1 selects paired (128-bit) organisation |
| cfg_swap | input | 1 | Exchange the two banks in split organisation |
| cfg_size | input | 2 | Device size code (bank depth) |
| rd_ready | output | 1 | Read complete, one-cycle pulse |
| rd_err | output | 1 | Unmapped read, with rd_ready |
| rd_data | output | 2*WORD_W | Read data |
| b1_en | output | 1 | Bank 1 read enable |
| b1_addr | output | SPACE_LOG2-4 | Bank 1 word address |
| b1_data | input | WORD_W | Bank 1 read data, one cycle after enable |
| b1_busy | input | 1 | Bank 1 is programming |
| b2_en | output | 1 | Bank 2 read enable |
| b2_addr | output | SPACE_LOG2-4 | Bank 2 word address |
| b2_data | input | WORD_W | Bank 2 read data, one cycle after enable |
| b2_busy | input | 1 | Bank 2 is programming |

## Verification
The bench builds the block with SPACE_LOG2=9. That gives 64 word addresses and banks of 32 words, small enough to sweep every address under every size code, both organisations and both exchange settings. The sweep takes in the inter-bank hole, the out-of-size lines and the invalid size code. The bench's bank models return a data pattern computed from the bank number and the word. As a result, a wrong bank, word or half-line shows up directly, and the bench can count the enables each read causes. Directed sequences hold the busy flags to cover the stall, read-while-write and mid-read configuration changes.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ISSUE,
    ST_CAPT
  } dbf_state_e;

  typedef struct packed {
    logic       single;
    logic       swap;
    logic [1:0] size;
  } dbf_cfg_t;

  localparam dbf_cfg_t CFG_RESET = '{single: 1'b0, swap: 1'b0, size: 2'd0};

endpackage

// File: rtl/dbf_decode.sv
module dbf_decode
  import dbf_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  dbf_cfg_t      cfg,
  output logic          ok,
  output logic [1:0]    need,
  output logic [AW-2:0] idx
);

  localparam int IW = AW - 1;
  localparam logic [IW:0] ONE = {{IW{1'b0}}, 1'b1};

  logic [IW:0] limit;
  logic        to_b2;

  // bank depth in words from the size code
  always_comb begin
    unique case (cfg.size)
      2'd0:    limit = ONE << IW;
      2'd1:    limit = ONE << (IW - 1);
      2'd2:    limit = ONE << (IW - 2);
      default: limit = '0;
    endcase
  end

  always_comb begin
    if (cfg.single) begin
      idx   = addr[AW-1:1];
      to_b2 = 1'b0;
    end else begin
      idx   = addr[IW-1:0];
      to_b2 = addr[AW-1] ^ cfg.swap;
    end
    ok = ({1'b0, idx} < limit);
    if (!ok)
      need = 2'b00;
    else if (cfg.single)
      need = 2'b11;
    else
      need = to_b2 ? 2'b10 : 2'b01;
  end

endmodule

// File: rtl/dbf_stall.sv
module dbf_stall (
  input  logic [1:0] need,
  input  logic [1:0] busy,
  output logic       stall
);

  logic [1:0] clash;

  for (genvar g = 0; g < 2; g++) begin : g_clash
    assign clash[g] = need[g] & busy[g];
  end

  assign stall = |clash;

endmodule

// File: rtl/dbf_seq.sv
module dbf_seq
  import dbf_pkg::*;
#(
  parameter int AW     = 16,
  parameter int WORD_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic [AW-1:0]       req_addr,
  input  dbf_cfg_t            cfg_in,
  input  logic                dec_ok,
  input  logic [1:0]          need,
  input  logic [AW-2:0]       idx,
  input  logic                stall,
  input  logic [WORD_W-1:0]   b1_data,
  input  logic [WORD_W-1:0]   b2_data,
  output logic [AW-1:0]       lat_addr,
  output dbf_cfg_t            lat_cfg,
  output dbf_state_e          state,
  output logic                rd_ready,
  output logic                rd_err,
  output logic [2*WORD_W-1:0] rd_data,
  output logic [1:0]          bank_en,
  output logic [AW-2:0]       b1_addr,
  output logic [AW-2:0]       b2_addr
);

  localparam int IW = AW - 1;

  logic          issue;
  logic          pick_b2;
  logic [IW-1:0] bank_addr_w [2];

  assign issue = (state == ST_WAIT) && dec_ok && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      lat_addr <= '0;
      lat_cfg  <= CFG_RESET;
      rd_ready <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
      pick_b2  <= 1'b0;
    end else begin
      rd_ready <= 1'b0;
      rd_err   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            lat_addr <= req_addr;
            lat_cfg  <= cfg_in;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!dec_ok) begin
            rd_ready <= 1'b1;
            rd_err   <= 1'b1;
            rd_data  <= '1;
            state    <= ST_IDLE;
          end else if (!stall) begin
            pick_b2 <= need[1] & ~lat_cfg.single;
            state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_CAPT;
        ST_CAPT: begin
          rd_ready <= 1'b1;
          if (lat_cfg.single)
            rd_data <= {b2_data, b1_data};
          else
            rd_data <= {{WORD_W{1'b0}}, (pick_b2 ? b2_data : b1_data)};
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // per-bank enable and address registers
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic          en_r;
    logic [IW-1:0] a_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        en_r <= 1'b0;
        a_r  <= '0;
      end else begin
        en_r <= issue & need[g];
        if (issue & need[g])
          a_r <= idx;
      end
    end
    assign bank_en[g]     = en_r;
    assign bank_addr_w[g] = a_r;
  end

  assign b1_addr = bank_addr_w[0];
  assign b2_addr = bank_addr_w[1];

endmodule

// File: rtl/dbf_addr_map.sv
module dbf_addr_map
  import dbf_pkg::*;
#(
  parameter int SPACE_LOG2 = 19,
  parameter int WORD_W     = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_req,
  input  logic [SPACE_LOG2-4:0]    rd_addr,
  input  logic                     cfg_single,
  input  logic                     cfg_swap,
  input  logic [1:0]               cfg_size,
  output logic                     rd_ready,
  output logic                     rd_err,
  output logic [2*WORD_W-1:0]      rd_data,
  output logic                     b1_en,
  output logic [SPACE_LOG2-5:0]    b1_addr,
  input  logic [WORD_W-1:0]        b1_data,
  input  logic                     b1_busy,
  output logic                     b2_en,
  output logic [SPACE_LOG2-5:0]    b2_addr,
  input  logic [WORD_W-1:0]        b2_data,
  input  logic                     b2_busy
);

  localparam int AW = SPACE_LOG2 - 3;
  localparam int IW = AW - 1;

  dbf_cfg_t   cfg_in;
  dbf_cfg_t   lat_cfg;
  dbf_state_e state;
  logic [AW-1:0] lat_addr;
  logic          dec_ok;
  logic [1:0]    need;
  logic [IW-1:0] idx;
  logic          stall;
  logic [1:0]    bank_en;

  assign cfg_in = '{single: cfg_single, swap: cfg_swap, size: cfg_size};

  dbf_decode #(.AW(AW)) u_dec (
    .addr (lat_addr),
    .cfg  (lat_cfg),
    .ok   (dec_ok),
    .need (need),
    .idx  (idx)
  );

  dbf_stall u_stall (
    .need  (need),
    .busy  ({b2_busy, b1_busy}),
    .stall (stall)
  );

  dbf_seq #(.AW(AW), .WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (rd_req),
    .req_addr (rd_addr),
    .cfg_in   (cfg_in),
    .dec_ok   (dec_ok),
    .need     (need),
    .idx      (idx),
    .stall    (stall),
    .b1_data  (b1_data),
    .b2_data  (b2_data),
    .lat_addr (lat_addr),
    .lat_cfg  (lat_cfg),
    .state    (state),
    .rd_ready (rd_ready),
    .rd_err   (rd_err),
    .rd_data  (rd_data),
    .bank_en  (bank_en),
    .b1_addr  (b1_addr),
    .b2_addr  (b2_addr)
  );

  assign b1_en = bank_en[0];
  assign b2_en = bank_en[1];

endmodule

// File: rtl/dbf_addr_map_chk.sv
module dbf_addr_map_chk
  import dbf_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_ready,
  input logic                rd_err,
  input logic [2*WORD_W-1:0] rd_data,
  input logic                b1_en,
  input logic                b2_en,
  input logic                dec_ok,
  input logic                stall,
  input dbf_state_e          state,
  input dbf_cfg_t            lat_cfg
);

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  a_r4_err_ones: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_ready && (&rd_data)));

  a_r4_err_no_bank: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !dec_ok) |=> (!b1_en && !b2_en));

  a_r2_pair_enable: assert property (@(posedge clk) disable iff (rst)
    ((b1_en || b2_en) && lat_cfg.single) |-> (b1_en && b2_en));

  a_r1_one_bank: assert property (@(posedge clk) disable iff (rst)
    ((b1_en || b2_en) && !lat_cfg.single) |-> ($countones({b1_en, b2_en}) == 1));

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (b1_en || b2_en) |-> ##2 (rd_ready && !rd_err));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && stall) |=> (!b1_en && !b2_en && !rd_ready));

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(lat_cfg));

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_ready && !rd_err && !b1_en && !b2_en));

endmodule

bind dbf_addr_map dbf_addr_map_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_ready (rd_ready),
  .rd_err   (rd_err),
  .rd_data  (rd_data),
  .b1_en    (b1_en),
  .b2_en    (b2_en),
  .dec_ok   (dec_ok),
  .stall    (stall),
  .state    (state),
  .lat_cfg  (lat_cfg)
);

// File: tb/dbf_addr_map_tb_top.sv
module dbf_addr_map_tb_top;

  localparam int L  = 9;
  localparam int W  = 64;
  localparam int AW = L - 3;
  localparam int IW = AW - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          cfg_single = 1'b0;
  logic          cfg_swap = 1'b0;
  logic [1:0]    cfg_size = 2'd0;
  logic          rd_ready, rd_err;
  logic [2*W-1:0] rd_data;
  logic          b1_en, b2_en;
  logic [IW-1:0] b1_addr, b2_addr;
  logic [W-1:0]  b1_data = '0;
  logic [W-1:0]  b2_data = '0;
  logic          b1_busy = 1'b0;
  logic          b2_busy = 1'b0;

  int checks = 0;
  int failures = 0;
  int en1_cnt = 0;
  int en2_cnt = 0;

  always #5 clk = ~clk;

  dbf_addr_map #(.SPACE_LOG2(L), .WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .cfg_single(cfg_single), .cfg_swap(cfg_swap), .cfg_size(cfg_size),
    .rd_ready(rd_ready), .rd_err(rd_err), .rd_data(rd_data),
    .b1_en(b1_en), .b1_addr(b1_addr), .b1_data(b1_data), .b1_busy(b1_busy),
    .b2_en(b2_en), .b2_addr(b2_addr), .b2_data(b2_data), .b2_busy(b2_busy)
  );

  function automatic logic [W-1:0] pat(int b, int w);
    return {8'(b), 8'h5A, 16'(w), 32'(w * 7 + b * 1000)};
  endfunction

  // bank models: one-cycle registered read
  always @(posedge clk) begin
    if (b1_en) begin
      b1_data <= pat(1, int'(b1_addr));
      en1_cnt <= en1_cnt + 1;
    end
    if (b2_en) begin
      b2_data <= pat(2, int'(b2_addr));
      en2_cnt <= en2_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int depth(int sz);
    return (sz == 0) ? 32 : (sz == 1) ? 16 : (sz == 2) ? 8 : 0;
  endfunction

  task automatic model(input int a, input bit sg, input bit sw, input int sz,
                       output bit ok, output logic [2*W-1:0] d, output int bank);
    int w;
    if (sg) begin
      w = a >> 1;
      ok = w < depth(sz);
      d = {pat(2, w), pat(1, w)};
      bank = 3;
    end else begin
      w = a & 31;
      ok = w < depth(sz);
      bank = (((a >> 5) & 1) ^ int'(sw)) != 0 ? 2 : 1;
      d = {64'h0, pat(bank, w)};
    end
    if (!ok) begin
      d = '1;
      bank = 0;
    end
  endtask

  task automatic launch(input int a, input bit sg, input bit sw, input int sz);
    @(negedge clk);
    rd_addr = AW'(a);
    cfg_single = sg;
    cfg_swap = sw;
    cfg_size = 2'(sz);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wait_ready(output int lat);
    lat = 1;
    while (!rd_ready && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic sweep_one(input int a, input bit sg, input bit sw, input int sz);
    bit ok;
    logic [2*W-1:0] d;
    int bank, lat, e1, e2;
    string tag;
    model(a, sg, sw, sz, ok, d, bank);
    e1 = en1_cnt;
    e2 = en2_cnt;
    launch(a, sg, sw, sz);
    wait_ready(lat);
    tag = sg ? ((a % 2) == 1 ? "R10" : "R2") : (sw ? "R5" : "R1");
    if (!ok) tag = "R3";
    chk(rd_err == !ok, {tag, " err flag"}, 128'(rd_err), 128'(!ok));
    chk(rd_data == d, {tag, " data"}, rd_data, d);
    if (ok) chk(lat == 4, "R1 latency", 128'(lat), 128'd4);
    else    chk(lat == 2, "R4 error latency", 128'(lat), 128'd2);
    chk((en1_cnt - e1) == ((bank == 1 || bank == 3) ? 1 : 0), "R4 bank1 enables",
        128'(en1_cnt - e1), 128'((bank == 1 || bank == 3) ? 1 : 0));
    chk((en2_cnt - e2) == ((bank == 2 || bank == 3) ? 1 : 0), "R4 bank2 enables",
        128'(en2_cnt - e2), 128'((bank == 2 || bank == 3) ? 1 : 0));
    @(negedge clk);
    chk(!rd_ready && !rd_err, "R11 pulse width", 128'({rd_ready, rd_err}), 128'd0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [2*W-1:0] d;
    repeat (3) @(negedge clk);
    // R9 during and after reset
    chk(!rd_ready && !rd_err && !b1_en && !b2_en && rd_data == '0, "R9 reset held",
        {rd_data[127:4], rd_ready, rd_err, b1_en, b2_en}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_ready && !rd_err && !b1_en && !b2_en && rd_data == '0, "R9 after reset",
        {rd_data[127:4], rd_ready, rd_err, b1_en, b2_en}, 128'd0);

    // exhaustive sweep
    for (int sz = 0; sz < 4; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int sw = 0; sw < 2; sw++)
          for (int a = 0; a < 64; a++)
            sweep_one(a, sg[0], sw[0], sz);

    // R6: read bank 1 while bank 2 programs
    b2_busy = 1'b1;
    launch(3, 1'b0, 1'b0, 0);
    wait_ready(lat);
    chk(lat == 4, "R6 no stall latency", 128'(lat), 128'd4);
    chk(rd_data == {64'h0, pat(1, 3)}, "R6 data", rd_data, {64'h0, pat(1, 3)});

    // R7: paired read stalls on bank 2 busy
    launch(6, 1'b1, 1'b0, 0);
    repeat (5) @(negedge clk);
    chk(!rd_ready, "R7 paired stall", 128'(rd_ready), 128'd0);
    b2_busy = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rd_ready, "R7 paired early", 128'(rd_ready), 128'd0);
    @(negedge clk);
    chk(rd_ready && rd_data == {pat(2, 3), pat(1, 3)}, "R7 paired resume",
        rd_data, {pat(2, 3), pat(1, 3)});

    // R7: split read stalls on its own bank
    b1_busy = 1'b1;
    launch(2, 1'b0, 1'b0, 0);
    for (int i = 0; i < 6; i++) begin
      chk(!rd_ready && !b1_en, "R7 split stall", 128'({rd_ready, b1_en}), 128'd0);
      @(negedge clk);
    end
    b1_busy = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rd_ready, "R7 split early", 128'(rd_ready), 128'd0);
    @(negedge clk);
    chk(rd_ready && rd_data == {64'h0, pat(1, 2)}, "R7 split resume",
        rd_data, {64'h0, pat(1, 2)});

    // R8: config and request changes while outstanding
    b1_busy = 1'b1;
    launch(4, 1'b0, 1'b0, 0);
    @(negedge clk);
    cfg_single = 1'b1;
    cfg_swap = 1'b1;
    cfg_size = 2'd3;
    rd_addr = AW'(40);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    b1_busy = 1'b0;
    wait_ready(lat);
    d = {64'h0, pat(1, 4)};
    chk(rd_ready && !rd_err && rd_data == d, "R8 latched config", rd_data, d);
    repeat (6) @(negedge clk);
    chk(!rd_ready, "R8 extra request ignored", 128'(rd_ready), 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule